// File: doc/BRIEF.md
# Serial Clock-Synthesizer Configuration Port

This block is the digital control front end of a programmable clock synthesizer. A host shifts a 24-bit configuration word in over three asynchronous wires: a serial clock, a data line and a strobe. The strobe moves the captured word into the active configuration register. The active word is decoded into the control fields that the analog PLL and the output dividers consume: reference divider, feedback divider, output divider select, second-output function, duty-cycle mode and crystal load setting.

Each strobe produces a one-cycle update pulse. Alongside it, the block reports whether the change can disturb the clock outputs. A change to the reference divider, feedback divider, duty mode or crystal load is smooth. A change to the output divider select or to the second-output function can glitch. A zero reference divider requests that the PLL be bypassed and switched off. An active-low power-down input disables both clock output drivers and raises a chip power-down flag. Serial programming keeps working while the chip is powered down, and the configuration survives the return to normal operation.

Top module: `clksyn_cfg_port`

## Requirements
- R1: Data is sampled on each rising edge of the serial clock and shifted in MSB first. Once a strobe has loaded a 24-bit word, the fields are taken from it as follows: bits 23:22 set load_cap, bit 21 sets duty_mode, bits 20:19 set out2_func, bits 18:16 set out_div_sel, bits 15:7 set fb_div, and bits 6:0 set ref_div. Bit 23 is the first bit sent.
- R2: The decoded outputs change only on a strobe rising edge. While a word is being shifted, they keep their previous values.
- R3: After reset, the active word is 0x230406. This decodes to load_cap=0, duty_mode=1, out2_func=0, out_div_sel=3, fb_div=8 and ref_div=6. After reset, upd_smooth=1 and both glitch flags are 0.
- R4: pll_bypass is 1 exactly when ref_div is 0.
- R5: While pd_n is low, clk1_oe and clk2_oe are 0 and chip_pwrdn is 1. While pd_n is high, clk1_oe and clk2_oe are 1 and chip_pwrdn is 0. A word shifted and strobed during power-down still becomes active.
- R6: Raising pd_n again does not change the active word.
- R7: cfg_updated is high for exactly one cycle per strobe rising edge. That cycle is SYNC_STAGES+1 system clocks after the strobe input rises. The classification flags change in that same cycle and hold until the next strobe.
- R8: If a strobe leaves out_div_sel and out2_func unchanged, then upd_smooth=1, upd_glitch1=0 and upd_glitch2=0. This covers a strobe that changes nothing.
- R9: A strobe that changes out_div_sel sets upd_glitch1=1 and upd_smooth=0. If the new out2_func is 3 (binary 11), the same strobe also sets upd_glitch2=1.
- R10: A strobe that changes out2_func sets upd_glitch2=1 and upd_smooth=0.
- R11: If more than 24 bits are shifted before a strobe, only the last 24 bits are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Asynchronous serial clock |
| ser_data | input | 1 | Asynchronous serial data |
| ser_strobe | input | 1 | Asynchronous load strobe |
| pd_n | input | 1 | Active-low power-down |
| ref_div | output | 7 | Reference divider word |
| fb_div | output | 9 | Feedback divider word |
| out_div_sel | output | 3 | Output divider select |
| out2_func | output | 2 | Second-output function |
| duty_mode | output | 1 | Duty-cycle setting |
| load_cap | output | 2 | Crystal load setting |
| pll_bypass | output | 1 | PLL off, reference passed straight to both outputs |
| chip_pwrdn | output | 1 | Chip power-down flag |
| clk1_oe | output | 1 | Output 1 driver enable |
| clk2_oe | output | 1 | Output 2 driver enable |
| cfg_updated | output | 1 | One-cycle pulse per strobe |
| upd_smooth | output | 1 | Last update was glitch-free |
| upd_glitch1 | output | 1 | Last update may glitch output 1 |
| upd_glitch2 | output | 1 | Last update may glitch output 2 |

## Verification
The hardest case to reach is the second-output glitch that comes from a divider-select change alone. To show it on its own, the function field must already be 11 before the update and must stay 11 through it. The stimulus therefore first loads a word that sets the function to 11. It then strobes a second word that changes only the divider select. A reference model tracks the synchronizer delay of the serial pins and is compared with every output on every clock. Programming during power-down, a zero reference divider and an over-long word are each driven as their own sequences.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
    localparam int CAP_W  = 2;
    localparam int DUTY_W = 1;
    localparam int FUNC_W = 2;
    localparam int SEL_W  = 3;
    localparam int FB_W   = 9;
    localparam int REF_W  = 7;
    localparam int WORD_W = CAP_W + DUTY_W + FUNC_W + SEL_W + FB_W + REF_W;

    // Field order follows shift order: first bit received lands in the MSB.
    typedef struct packed {
        logic [CAP_W-1:0]  load_cap;
        logic [DUTY_W-1:0] duty_mode;
        logic [FUNC_W-1:0] out2_func;
        logic [SEL_W-1:0]  out_div_sel;
        logic [FB_W-1:0]   fb_div;
        logic [REF_W-1:0]  ref_div;
    } cfg_word_t;

    typedef struct packed {
        logic smooth;
        logic glitch1;
        logic glitch2;
    } upd_class_t;

    localparam cfg_word_t  CFG_DEFAULT      = cfg_word_t'(24'h230406);
    localparam upd_class_t CLASS_RESET      = '{smooth: 1'b1, glitch1: 1'b0, glitch2: 1'b0};
    localparam logic [FUNC_W-1:0] FUNC_TRACKS_DIV = 2'b11;

    function automatic upd_class_t classify(input cfg_word_t old_w, input cfg_word_t new_w);
        upd_class_t c;
        logic sel_moved;
        logic func_moved;
        sel_moved  = (old_w.out_div_sel != new_w.out_div_sel);
        func_moved = (old_w.out2_func != new_w.out2_func);
        c.glitch1  = sel_moved;
        c.glitch2  = func_moved || (sel_moved && (new_w.out2_func == FUNC_TRACKS_DIV));
        c.smooth   = !c.glitch1 && !c.glitch2;
        return c;
    endfunction

    function automatic logic ref_is_zero(input cfg_word_t w);
        return (w.ref_div == '0);
    endfunction
endpackage

// File: rtl/clksyn_sync.sv
module clksyn_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] q
);
    localparam int LEN = STAGES + (EDGE ? 1 : 0);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [LEN-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[LEN-2:0], async_in[i]};
        end

        if (EDGE) begin : g_edge
            assign q[i] = chain[STAGES-1] & ~chain[STAGES];

            // R7: an edge detect output never lasts two cycles
            a_r7_edge_single: assert property (@(posedge clk) disable iff (rst)
                q[i] |=> !q[i]);
        end else begin : g_level
            assign q[i] = chain[STAGES-1];
        end
    end
endmodule

// File: rtl/clksyn_shifter.sv
module clksyn_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end

    // R1: the newest bit enters at the LSB on a shift
    a_r1_lsb_entry: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (word[0] == $past(bit_in)));

    // R2: without a serial clock edge the captured bits hold
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/clksyn_active_reg.sv
module clksyn_active_reg
    import clksyn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cfg_word_t  incoming,
    output cfg_word_t  active,
    output logic       updated,
    output upd_class_t cls
);
    upd_class_t cls_next;

    always_comb cls_next = classify(active, incoming);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= CFG_DEFAULT;
            updated <= 1'b0;
            cls     <= CLASS_RESET;
        end else begin
            updated <= load;
            if (load) begin
                active <= incoming;
                cls    <= cls_next;
            end
        end
    end

    // R7: class flags change only together with an update pulse
    a_r7_flags_with_pulse: assert property (@(posedge clk) disable iff (rst)
        !updated |-> $stable(cls) || $past(rst));
endmodule

// File: rtl/clksyn_cfg_port.sv
module clksyn_cfg_port
    import clksyn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_strobe,
    input  logic              pd_n,
    output logic [REF_W-1:0]  ref_div,
    output logic [FB_W-1:0]   fb_div,
    output logic [SEL_W-1:0]  out_div_sel,
    output logic [FUNC_W-1:0] out2_func,
    output logic              duty_mode,
    output logic [CAP_W-1:0]  load_cap,
    output logic              pll_bypass,
    output logic              chip_pwrdn,
    output logic              clk1_oe,
    output logic              clk2_oe,
    output logic              cfg_updated,
    output logic              upd_smooth,
    output logic              upd_glitch1,
    output logic              upd_glitch2
);
    logic [1:0]        edges;
    logic [0:0]        data_sync;
    logic [WORD_W-1:0] shift_word;
    cfg_word_t         active;
    upd_class_t        cls;

    // edges[1] = serial clock rise, edges[0] = strobe rise
    clksyn_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .EDGE(1'b1)) u_edge (
        .clk(clk), .rst(rst), .async_in({ser_clk, ser_strobe}), .q(edges));

    clksyn_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .EDGE(1'b0)) u_data (
        .clk(clk), .rst(rst), .async_in(ser_data), .q(data_sync));

    clksyn_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(edges[1]), .bit_in(data_sync[0]),
        .word(shift_word));

    clksyn_active_reg u_active (
        .clk(clk), .rst(rst), .load(edges[0]), .incoming(cfg_word_t'(shift_word)),
        .active(active), .updated(cfg_updated), .cls(cls));

    always_comb begin
        ref_div     = active.ref_div;
        fb_div      = active.fb_div;
        out_div_sel = active.out_div_sel;
        out2_func   = active.out2_func;
        duty_mode   = active.duty_mode;
        load_cap    = active.load_cap;
        pll_bypass  = ref_is_zero(active);
        chip_pwrdn  = !pd_n;
        clk1_oe     = pd_n;
        clk2_oe     = pd_n;
        upd_smooth  = cls.smooth;
        upd_glitch1 = cls.glitch1;
        upd_glitch2 = cls.glitch2;
    end

    // R3: the first cycle out of reset shows the default word
    a_r3_default_word: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (active == CFG_DEFAULT));

    // R2: the active word moves only after a strobe edge
    a_r2_no_load_no_change: assert property (@(posedge clk) disable iff (rst)
        !edges[0] |=> $stable(active));

    // R7: the update pulse lasts one cycle
    a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
        cfg_updated |=> !cfg_updated);

    // R9: a new divider select is flagged for output 1
    a_r9_sel_flagged: assert property (@(posedge clk) disable iff (rst)
        (cfg_updated && !$past(rst) && (out_div_sel != $past(out_div_sel))) |-> upd_glitch1);

    // R10: a new second-output function is flagged for output 2
    a_r10_func_flagged: assert property (@(posedge clk) disable iff (rst)
        (cfg_updated && !$past(rst) && (out2_func != $past(out2_func))) |-> upd_glitch2);
endmodule

// File: tb/sim_clksyn_cfg_port.sv
module sim_clksyn_cfg_port;
    import clksyn_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, pd_n = 1'b1;
    logic [6:0] ref_div;
    logic [8:0] fb_div;
    logic [2:0] out_div_sel;
    logic [1:0] out2_func, load_cap;
    logic duty_mode, pll_bypass, chip_pwrdn, clk1_oe, clk2_oe;
    logic cfg_updated, upd_smooth, upd_glitch1, upd_glitch2;

    always #4 clk = ~clk;  // 125 MHz

    clksyn_cfg_port u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .pd_n(pd_n), .ref_div(ref_div), .fb_div(fb_div),
        .out_div_sel(out_div_sel), .out2_func(out2_func), .duty_mode(duty_mode),
        .load_cap(load_cap), .pll_bypass(pll_bypass), .chip_pwrdn(chip_pwrdn),
        .clk1_oe(clk1_oe), .clk2_oe(clk2_oe), .cfg_updated(cfg_updated),
        .upd_smooth(upd_smooth), .upd_glitch1(upd_glitch1), .upd_glitch2(upd_glitch2));

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input int c, input int t, input int f,
                                       input int s, input int v, input int r);
        logic [23:0] w;
        w[23:22] = 2'(c); w[21] = 1'(t); w[20:19] = 2'(f);
        w[18:16] = 3'(s); w[15:7] = 9'(v); w[6:0] = 7'(r);
        return w;
    endfunction

    // Reference model: pins take three system edges to act (two sync stages + edge)
    logic [3:0] h_clk, h_dat, h_stb;
    logic [23:0] m_shift, m_active;
    logic m_upd, m_smooth, m_g1, m_g2;

    always @(posedge clk) begin
        if (rst) begin
            h_clk = '0; h_dat = '0; h_stb = '0;
            m_shift = '0; m_active = 24'h230406;
            m_upd = 0; m_smooth = 1; m_g1 = 0; m_g2 = 0;
        end else begin
            h_clk = {h_clk[2:0], ser_clk};
            h_dat = {h_dat[2:0], ser_data};
            h_stb = {h_stb[2:0], ser_strobe};
            m_upd = h_stb[2] && !h_stb[3];
            if (m_upd) begin
                m_g1 = m_shift[18:16] != m_active[18:16];
                m_g2 = (m_shift[20:19] != m_active[20:19]) ||
                       (m_g1 && m_shift[20:19] == 2'b11);
                m_smooth = !m_g1 && !m_g2;
                m_active = m_shift;
            end
            if (h_clk[2] && !h_clk[3]) m_shift = {m_shift[22:0], h_dat[2]};
        end
    end

    // Compare against the model away from the active edge, every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 active word", int'({load_cap, duty_mode, out2_func, out_div_sel, fb_div, ref_div}),
                int'(m_active));
            chk("R4 pll_bypass", int'(pll_bypass), int'(m_active[6:0] == 7'd0));
            chk("R5 output enables", int'({chip_pwrdn, clk1_oe, clk2_oe}),
                int'({!pd_n, pd_n, pd_n}));
            chk("R7 cfg_updated", int'(cfg_updated), int'(m_upd));
            chk("R8 upd_smooth", int'(upd_smooth), int'(m_smooth));
            chk("R9 upd_glitch1", int'(upd_glitch1), int'(m_g1));
            chk("R10 upd_glitch2", int'(upd_glitch2), int'(m_g2));
            if (cfg_updated) pulses++;
        end
    end

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) ser_data = v[i];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic strobe();
        @(negedge clk) ser_strobe = 1'b1;
        repeat (4) @(negedge clk);
        ser_strobe = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_flags(input string req, input int s, input int g1, input int g2);
        chk(req, int'({upd_smooth, upd_glitch1, upd_glitch2}), (s << 2) | (g1 << 1) | g2);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [23:0] w;
        int p0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3: reset defaults
        chk("R3 default word", int'({load_cap, duty_mode, out2_func, out_div_sel, fb_div, ref_div}),
            int'(24'h230406));
        chk("R3 fb_div", int'(fb_div), 8);
        chk("R3 ref_div", int'(ref_div), 6);
        expect_flags("R3 reset flags", 1, 0, 0);

        // R2 + R8: smooth change of dividers only; outputs hold mid-shift
        w = mk(0, 1, 0, 3, 9'h50, 7'h11);
        send_bits(64'(w >> 12), 12);
        chk("R2 held mid-shift", int'(ref_div), 6);
        send_bits(64'(w), 12);
        chk("R2 held before strobe", int'(fb_div), 8);
        p0 = pulses;
        strobe();
        chk("R1 fb_div loaded", int'(fb_div), 9'h50);
        chk("R7 one pulse per strobe", pulses - p0, 1);
        expect_flags("R8 divider-only change smooth", 1, 0, 0);

        // R4: zero reference divider
        send_bits(64'(mk(2, 0, 0, 3, 9'h50, 0)), 24); strobe();
        chk("R4 bypass on zero ref", int'(pll_bypass), 1);
        chk("R1 load_cap", int'(load_cap), 2);
        expect_flags("R8 cap/duty/ref change smooth", 1, 0, 0);

        // R9: select change, function 00
        send_bits(64'(mk(2, 0, 0, 5, 9'h50, 3)), 24); strobe();
        chk("R4 bypass off", int'(pll_bypass), 0);
        expect_flags("R9 select change", 0, 1, 0);

        // R10: function becomes 11 (select held)
        send_bits(64'(mk(2, 0, 3, 5, 9'h50, 3)), 24); strobe();
        expect_flags("R10 function change", 0, 0, 1);

        // R9: select change with function staying 11
        send_bits(64'(mk(2, 0, 3, 1, 9'h50, 3)), 24); strobe();
        expect_flags("R9 select change, function 11", 0, 1, 1);

        // R10: function change only
        send_bits(64'(mk(2, 0, 1, 1, 9'h50, 3)), 24); strobe();
        expect_flags("R10 function-only change", 0, 0, 1);

        // R8: strobe with no change
        p0 = pulses;
        strobe();
        chk("R7 repeat strobe pulse", pulses - p0, 1);
        expect_flags("R8 no change", 1, 0, 0);

        // R5: program during power-down
        @(negedge clk) pd_n = 1'b0;
        @(negedge clk);
        chk("R5 oe low in power-down", int'({clk1_oe, clk2_oe}), 0);
        chk("R5 chip_pwrdn", int'(chip_pwrdn), 1);
        send_bits(64'(mk(1, 1, 1, 1, 9'h1AB, 7'h45)), 24); strobe();
        chk("R5 load during power-down", int'(fb_div), 9'h1AB);
        // R6: leaving power-down keeps the word
        @(negedge clk) pd_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 word kept", int'({load_cap, duty_mode, out2_func, out_div_sel, fb_div, ref_div}),
            int'(mk(1, 1, 1, 1, 9'h1AB, 7'h45)));
        chk("R5 oe restored", int'({clk1_oe, clk2_oe, chip_pwrdn}), 3'b110);

        // R11: over-long word keeps the last 24 bits
        send_bits({34'd0, 6'b101101, mk(0, 0, 1, 1, 9'h0F0, 7'h7F)}, 30); strobe();
        chk("R11 last 24 bits", int'({load_cap, duty_mode, out2_func, out_div_sel, fb_div, ref_div}),
            int'(mk(0, 0, 1, 1, 9'h0F0, 7'h7F)));

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule